// File: doc/BRIEF.md
# SCSI Transfer Count Unit

This block keeps the byte count for a SCSI host adapter's data transfers and turns it into the length of each individual move. Software loads a 16-bit count one byte at a time into a shadow copy. A command carrying the DMA flag copies that shadow into the live count. A transfer-information command then works out how many bytes to move from three things: the live count, the signed number of bytes the SCSI side has pending, and a flag saying whether the bus is in the command phase.

When the transfer-information command also carries the DMA flag, the computed length seeds a DMA-remaining counter. An outside DMA engine reports progress through byte-count beats and can also signal the end of a segment. When the remaining count runs out, the block raises a terminal-count status bit, zeroes the live count and pulses a done output for one cycle. A zero count means the full 65536-byte range. The length is capped at 32 bytes in the command phase and by the size of the pending count otherwise.

Top module: `xfer_count_unit`

## Requirements
- R1: After reset the live count, transfer length, DMA-remaining value, direction, terminal-count bit and done pulse are all zero.
- R2: A register write with select 0 stores the low byte of the shadow count and select 1 stores the high byte. The live count does not change until a DMA command arrives.
- R3: Any count register write clears the terminal-count bit on the next cycle, unless a completion happens in that same cycle.
- R4: A command whose bit 7 is set loads the live count from the shadow count on the next cycle. A command with bit 7 clear leaves the live count unchanged.
- R5: A transfer-information command (low seven bits equal to 0x10) treats a count of zero as 65536 bytes. The length is never above 65536.
- R6: With the command-phase flag set, the length is the smaller of the count and 32.
- R7: With the command-phase flag clear, the length is the smaller of the count and the magnitude of the signed pending count. The direction output is 1 (toward the target) when the pending count is negative. When bit 7 is also set, the count used is the freshly reloaded one.
- R8: A transfer-information command with bit 7 set loads DMA-remaining with the length and clears the terminal-count bit. Without bit 7, both are left unchanged.
- R9: Each beat lowers DMA-remaining by the reported byte count, and the value stops at zero instead of wrapping.
- R10: When DMA-remaining goes from nonzero to zero, done_pulse is high for exactly one cycle. In that same cycle the terminal-count bit is set and the live count reads zero.
- R11: An end-of-segment input forces DMA-remaining to zero, sets the terminal-count bit and zeroes the live count. It pulses done when DMA-remaining was nonzero.
- R12: In a cycle that carries a command, beats and end-of-segment are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr_en | input | 1 | Count register write strobe |
| reg_wr_sel | input | 1 | 0 = low byte, 1 = high byte |
| reg_wr_data | input | 8 | Write data |
| cmd_valid | input | 1 | Command strobe |
| cmd_code | input | 8 | Command code; bit 7 = DMA flag |
| cmd_phase | input | 1 | Bus is in command phase |
| pend_cnt | input | 18 | Signed pending byte count |
| beat_valid | input | 1 | DMA progress beat |
| beat_bytes | input | 8 | Bytes moved on this beat |
| seg_end | input | 1 | DMA segment finished |
| live_count | output | 16 | Live transfer count |
| xfer_len | output | 17 | Computed transfer length |
| dma_remaining | output | 17 | Bytes left in the DMA transfer |
| to_target | output | 1 | Direction of the last computed transfer |
| tc_status | output | 1 | Terminal-count status bit |
| done_pulse | output | 1 | One-cycle completion pulse |

## Verification
The assertions check several things on every cycle: that a count write clears terminal count, that the command-phase length never exceeds 32, and that the length never exceeds 65536. They also check that DMA-remaining never rises outside a command, that non-DMA commands leave the live count and remaining value alone, and that each done pulse is single and comes with terminal count set and a zeroed live count. Only the bench scenarios can show the exact computed values. These include the zero-means-65536 rule, the minimum against a negative pending count, the use of a count reloaded in the same cycle, the clamping of an oversized beat, and a beat ignored during a command.

// File: rtl/xcu_pkg.sv
package xcu_pkg;
    localparam int BYTE_W = 8;
    localparam int CNT_W  = 2 * BYTE_W;
    localparam int LEN_W  = CNT_W + 1;
    localparam int DMA_FLAG_BIT = 7;

    typedef enum logic {
        SEL_LOW = 1'b0,
        SEL_HIGH = 1'b1
    } cnt_sel_e;
endpackage

// File: rtl/xcu_len_calc.sv
module xcu_len_calc
    import xcu_pkg::*;
#(
    parameter int PEND_W  = 18,
    parameter int CMD_CAP = 32
) (
    input  logic [CNT_W-1:0]         count_in,
    input  logic                     phase_in,
    input  logic signed [PEND_W-1:0] pend_in,
    output logic [LEN_W-1:0]         len_out
);
    localparam int MAG_W = (PEND_W > LEN_W) ? PEND_W : LEN_W;

    logic [MAG_W-1:0] full_w;
    logic [MAG_W-1:0] mag_w;
    logic [MAG_W-1:0] cap_w;
    logic [MAG_W-1:0] pick_w;

    always_comb begin
        full_w = '0;
        if (count_in == '0) begin
            full_w[CNT_W] = 1'b1;
        end else begin
            full_w[CNT_W-1:0] = count_in;
        end
        mag_w = '0;
        if (pend_in[PEND_W-1]) begin
            mag_w[PEND_W-1:0] = ~pend_in + 1'b1;
        end else begin
            mag_w[PEND_W-1:0] = pend_in;
        end
        cap_w  = phase_in ? MAG_W'(CMD_CAP) : mag_w;
        pick_w = (full_w < cap_w) ? full_w : cap_w;
        len_out = pick_w[LEN_W-1:0];
    end
endmodule

// File: rtl/xcu_rem_step.sv
module xcu_rem_step
    import xcu_pkg::*;
#(
    parameter int BEAT_W = 8
) (
    input  logic [LEN_W-1:0]  rem_in,
    input  logic              beat_in,
    input  logic [BEAT_W-1:0] bytes_in,
    input  logic              seg_in,
    output logic [LEN_W-1:0]  rem_out,
    output logic              hit_zero
);
    logic [LEN_W-1:0] dec_w;

    always_comb begin
        dec_w = beat_in ? LEN_W'(bytes_in) : '0;
        if (seg_in || dec_w >= rem_in) begin
            rem_out = '0;
        end else begin
            rem_out = rem_in - dec_w;
        end
        hit_zero = (rem_in != '0) && (rem_out == '0);
    end
endmodule

// File: rtl/xfer_count_unit.sv
module xfer_count_unit
    import xcu_pkg::*;
#(
    parameter int         PEND_W  = 18,
    parameter int         BEAT_W  = 8,
    parameter int         CMD_CAP = 32,
    parameter logic [6:0] TI_OP   = 7'h10
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     reg_wr_en,
    input  logic                     reg_wr_sel,
    input  logic [7:0]               reg_wr_data,
    input  logic                     cmd_valid,
    input  logic [7:0]               cmd_code,
    input  logic                     cmd_phase,
    input  logic signed [PEND_W-1:0] pend_cnt,
    input  logic                     beat_valid,
    input  logic [BEAT_W-1:0]        beat_bytes,
    input  logic                     seg_end,
    output logic [15:0]              live_count,
    output logic [16:0]              xfer_len,
    output logic [16:0]              dma_remaining,
    output logic                     to_target,
    output logic                     tc_status,
    output logic                     done_pulse
);
    typedef struct packed {
        logic [BYTE_W-1:0] sh_lo;
        logic [BYTE_W-1:0] sh_hi;
        logic [CNT_W-1:0]  live;
        logic [LEN_W-1:0]  len;
        logic [LEN_W-1:0]  rem;
        logic              dir;
        logic              tc;
        logic              done;
    } state_t;

    state_t st_d, st_q;

    logic             is_dma_w;
    logic             is_ti_w;
    logic [CNT_W-1:0] eff_cnt_w;
    logic [LEN_W-1:0] calc_len_w;
    logic [LEN_W-1:0] rem_next_w;
    logic             hit_zero_w;

    assign is_dma_w  = cmd_valid && cmd_code[DMA_FLAG_BIT];
    assign is_ti_w   = cmd_valid && (cmd_code[6:0] == TI_OP);
    assign eff_cnt_w = is_dma_w ? {st_q.sh_hi, st_q.sh_lo} : st_q.live;

    xcu_len_calc #(.PEND_W(PEND_W), .CMD_CAP(CMD_CAP)) len_calc_i (
        .count_in (eff_cnt_w),
        .phase_in (cmd_phase),
        .pend_in  (pend_cnt),
        .len_out  (calc_len_w)
    );

    xcu_rem_step #(.BEAT_W(BEAT_W)) rem_step_i (
        .rem_in   (st_q.rem),
        .beat_in  (beat_valid),
        .bytes_in (beat_bytes),
        .seg_in   (seg_end),
        .rem_out  (rem_next_w),
        .hit_zero (hit_zero_w)
    );

    always_comb begin
        st_d = st_q;
        st_d.done = 1'b0;
        if (reg_wr_en) begin
            if (cnt_sel_e'(reg_wr_sel) == SEL_LOW) begin
                st_d.sh_lo = reg_wr_data;
            end else begin
                st_d.sh_hi = reg_wr_data;
            end
            st_d.tc = 1'b0;
        end
        if (cmd_valid) begin
            if (is_dma_w) begin
                st_d.live = {st_q.sh_hi, st_q.sh_lo};
            end
            if (is_ti_w) begin
                st_d.len = calc_len_w;
                st_d.dir = pend_cnt[PEND_W-1];
                if (is_dma_w) begin
                    st_d.rem = calc_len_w;
                    st_d.tc  = 1'b0;
                end
            end
        end else begin
            st_d.rem = rem_next_w;
            if (hit_zero_w) begin
                st_d.done = 1'b1;
            end
            if (hit_zero_w || seg_end) begin
                st_d.tc   = 1'b1;
                st_d.live = '0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign live_count    = st_q.live;
    assign xfer_len      = st_q.len;
    assign dma_remaining = st_q.rem;
    assign to_target     = st_q.dir;
    assign tc_status     = st_q.tc;
    assign done_pulse    = st_q.done;
endmodule

// File: rtl/xcu_checker.sv
module xcu_checker #(
    parameter int         PEND_W  = 18,
    parameter int         BEAT_W  = 8,
    parameter int         CMD_CAP = 32,
    parameter logic [6:0] TI_OP   = 7'h10
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     reg_wr_en,
    input logic                     cmd_valid,
    input logic [7:0]               cmd_code,
    input logic                     cmd_phase,
    input logic signed [PEND_W-1:0] pend_cnt,
    input logic                     beat_valid,
    input logic [BEAT_W-1:0]        beat_bytes,
    input logic                     seg_end,
    input logic [15:0]              live_count,
    input logic [16:0]              xfer_len,
    input logic [16:0]              dma_remaining,
    input logic                     tc_status,
    input logic                     done_pulse
);
    assert_tc_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr_en && !cmd_valid && !beat_valid && !seg_end) |=> !tc_status);

    assert_live_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !cmd_code[7]) |=> $stable(live_count));

    assert_len_max_R5: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_len <= 17'd65536);

    assert_phase_cap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_code[6:0] == TI_OP && cmd_phase) |=> (xfer_len <= 17'(CMD_CAP)));

    assert_rem_no_rise_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_valid |=> (dma_remaining <= $past(dma_remaining)));

    assert_done_state_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done_pulse |-> (dma_remaining == '0 && tc_status && live_count == '0));

    assert_done_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done_pulse |=> !done_pulse);

    assert_cmd_rem_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !(cmd_code[7] && cmd_code[6:0] == TI_OP)) |=> $stable(dma_remaining));
endmodule

bind xfer_count_unit xcu_checker #(
    .PEND_W(PEND_W), .BEAT_W(BEAT_W), .CMD_CAP(CMD_CAP), .TI_OP(TI_OP)
) chk_i (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .cmd_valid(cmd_valid),
    .cmd_code(cmd_code), .cmd_phase(cmd_phase), .pend_cnt(pend_cnt),
    .beat_valid(beat_valid), .beat_bytes(beat_bytes), .seg_end(seg_end),
    .live_count(live_count), .xfer_len(xfer_len), .dma_remaining(dma_remaining),
    .tc_status(tc_status), .done_pulse(done_pulse)
);

// File: tb/xfer_count_unit_tb_top.sv
module xfer_count_unit_tb_top;
    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               reg_wr_en = 1'b0;
    logic               reg_wr_sel = 1'b0;
    logic [7:0]         reg_wr_data = '0;
    logic               cmd_valid = 1'b0;
    logic [7:0]         cmd_code = '0;
    logic               cmd_phase = 1'b0;
    logic signed [17:0] pend_cnt = '0;
    logic               beat_valid = 1'b0;
    logic [7:0]         beat_bytes = '0;
    logic               seg_end = 1'b0;
    logic [15:0]        live_count;
    logic [16:0]        xfer_len;
    logic [16:0]        dma_remaining;
    logic               to_target;
    logic               tc_status;
    logic               done_pulse;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #2 clk = ~clk;

    xfer_count_unit dut_i (
        .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_wr_sel(reg_wr_sel),
        .reg_wr_data(reg_wr_data), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
        .cmd_phase(cmd_phase), .pend_cnt(pend_cnt), .beat_valid(beat_valid),
        .beat_bytes(beat_bytes), .seg_end(seg_end), .live_count(live_count),
        .xfer_len(xfer_len), .dma_remaining(dma_remaining), .to_target(to_target),
        .tc_status(tc_status), .done_pulse(done_pulse)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 20000) begin
            errors = errors + 1;
            checks = checks + 1;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic chk(input string tag, input longint act, input longint exp);
        checks = checks + 1;
        if (act != exp) begin
            errors = errors + 1;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
        reg_wr_en = 1'b0; cmd_valid = 1'b0; beat_valid = 1'b0; seg_end = 1'b0;
        @(negedge clk);
    endtask

    task automatic wr(input logic sel, input logic [7:0] val);
        reg_wr_en = 1'b1; reg_wr_sel = sel; reg_wr_data = val;
        tick();
    endtask

    task automatic cmd(input logic [7:0] code, input logic ph, input int pend);
        cmd_valid = 1'b1; cmd_code = code; cmd_phase = ph; pend_cnt = 18'(pend);
        tick();
    endtask

    task automatic beat(input logic [7:0] n);
        beat_valid = 1'b1; beat_bytes = n;
        tick();
    endtask

    task automatic t_reset();
        chk("R1 live", live_count, 0);
        chk("R1 len", xfer_len, 0);
        chk("R1 rem", dma_remaining, 0);
        chk("R1 tc", tc_status, 0);
        chk("R1 done", done_pulse, 0);
        chk("R1 dir", to_target, 0);
    endtask

    task automatic t_load();
        wr(1'b0, 8'h34);
        wr(1'b1, 8'h12);
        chk("R2 live untouched", live_count, 0);
        cmd(8'h80, 1'b0, 0);
        chk("R4 reload", live_count, 16'h1234);
        cmd(8'h00, 1'b0, 0);
        chk("R4 non-dma hold", live_count, 16'h1234);
    endtask

    task automatic t_phase();
        cmd(8'h10, 1'b1, 500);
        chk("R6 phase cap", xfer_len, 32);
        chk("R8 no dma rem", dma_remaining, 0);
    endtask

    task automatic t_dma_in();
        wr(1'b0, 8'h00);
        wr(1'b1, 8'h01);
        cmd(8'h90, 1'b0, 100);
        chk("R7 min pend", xfer_len, 100);
        chk("R7 dir host", to_target, 0);
        chk("R7 reloaded", live_count, 16'h0100);
        chk("R8 rem load", dma_remaining, 100);
        beat(8'd40);
        chk("R9 beat1", dma_remaining, 60);
        chk("R9 no done", done_pulse, 0);
        beat(8'd40);
        chk("R9 beat2", dma_remaining, 20);
        beat(8'd50);
        chk("R9 saturate", dma_remaining, 0);
        chk("R10 done", done_pulse, 1);
        chk("R10 tc", tc_status, 1);
        chk("R10 live zero", live_count, 0);
        tick();
        chk("R10 done once", done_pulse, 0);
        chk("R10 tc held", tc_status, 1);
    endtask

    task automatic t_tc_clear();
        wr(1'b0, 8'h00);
        chk("R3 tc cleared", tc_status, 0);
    endtask

    task automatic t_zero_count();
        wr(1'b1, 8'h00);
        cmd(8'h90, 1'b0, -70000);
        chk("R5 zero is 65536", xfer_len, 65536);
        chk("R7 dir target", to_target, 1);
        chk("R8 rem 65536", dma_remaining, 65536);
        seg_end = 1'b1;
        tick();
        chk("R11 rem zero", dma_remaining, 0);
        chk("R11 done", done_pulse, 1);
        chk("R11 tc", tc_status, 1);
        chk("R11 live zero", live_count, 0);
    endtask

    task automatic t_cmd_ignore();
        beat_valid = 1'b1; beat_bytes = 8'd5;
        cmd(8'h90, 1'b0, 10);
        chk("R12 beat ignored", dma_remaining, 10);
        chk("R8 tc cleared", tc_status, 0);
        beat(8'd200);
        chk("R9 big beat", dma_remaining, 0);
        chk("R10 done big", done_pulse, 1);
        cmd(8'h10, 1'b0, 0);
        chk("R7 zero pend", xfer_len, 0);
    endtask

    initial begin
        @(negedge clk);
        @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_load();
        t_phase();
        t_dma_in();
        t_tc_clear();
        t_zero_count();
        t_cmd_ignore();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule